// File: doc/BRIEF.md
# External Data-Memory Bus Sequencer with Programmable Stretch

This block runs single accesses on a multiplexed external data-memory bus for a small 8-bit controller core. A request carries a direction, a 16-bit address, write data and a 3-bit stretch setting. The controller accepts the request only while it is idle. It then runs four timed phases: an address phase, a setup gap, the active-low read or write strobe and a hold gap. After the hold gap it gives a one-cycle completion pulse.

During the address phase the low address byte goes out on the shared address/data port and is qualified by a high-going address latch strobe. The high address byte stays on its own port for the whole access. On a read the shared port is released and the input byte is sampled at the last clock of the strobe. On a write the port drives the data from the setup gap through the hold gap.

The stretch setting exists so that slow RAM and peripherals can keep up. Its decode is not linear. Settings 1 to 3 add one clock of setup, one clock of hold and a wider strobe. Settings 4 to 7 also widen the address latch strobe and add a four-clock stretch period to each of the setup and hold gaps.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: After reset the outputs are idle: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `busy`=0.
- R2: An access lasts 8 + 4*N clocks from the first address-latch clock to the last hold clock. N is 0,1,2,3,7,8,9,10 for settings 0 to 7.
- R3: The strobe is low for 2 clocks at setting 0 and for 4*setting clocks at settings 1 to 7 (4 up to 28).
- R4: At settings 0 to 3 the address latch pulse lasts 2 clocks. The setup gap (latch low to strobe low) and the hold gap (strobe high to done) each last 2 clocks at setting 0 and 3 clocks at settings 1 to 3.
- R5: At settings 4 to 7 the address latch pulse lasts 6 clocks, and the setup and hold gaps each last 7 clocks.
- R6: A request with `req_wr`=1 pulses only `wr_n`, and one with `req_wr`=0 pulses only `rd_n`. The two strobes are never low together, and neither is low while `ale` is high.
- R7: During the address latch pulse `ad_oe`=1 and `ad_out` carries address bits [7:0]. During a write strobe `ad_oe`=1 and `ad_out` carries the write byte. During a read strobe `ad_oe`=0.
- R8: `addr_hi` carries address bits [15:8] for the whole access.
- R9: On a read, `rd_data` at the done pulse equals `ad_in` as it stood on the last clock that `rd_n` was low.
- R10: `done` is high for exactly one clock after the hold gap. A request raised while `busy`=1 is ignored and starts no access.
- R11: The stretch setting is taken when a request is accepted. Changing `req_sel` later does not alter the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, accepted when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Stretch setting |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Captured read byte |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared port drive value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port input value |

## Verification
The assertions check the bus rules on every clock. These are the decode sum against the stretch table, the exclusive strobes, a released port during reads, a stable high address byte under a strobe, a stretch setting that does not move mid-access, and a completion state that lasts one clock. Phase widths, the captured read byte and the rejection of requests made while busy can only be shown by the bench's scenarios. The bench runs every setting in both directions, deliberately disturbs `req` and `req_sel` during a long access, and measures each phase at the pins.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE    = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4,
    PH_DONE   = 3'd5
  } phase_e;
endpackage

// File: rtl/xmem_stretch_decode.sv
module xmem_stretch_decode #(
  parameter int MC_CLKS = 4,
  parameter int CNT_W   = 6
) (
  input  logic [2:0]       sel,
  output logic [CNT_W-1:0] ale_len,
  output logic [CNT_W-1:0] setup_len,
  output logic [CNT_W-1:0] strobe_len,
  output logic [CNT_W-1:0] hold_len
);
  localparam int HALF = MC_CLKS / 2;

  logic hi_rng;
  logic any_str;

  always_comb begin
    hi_rng     = sel[2];
    any_str    = (sel != 3'd0);
    ale_len    = CNT_W'(HALF + (hi_rng ? MC_CLKS : 0));
    setup_len  = CNT_W'(HALF + (any_str ? 1 : 0) + (hi_rng ? MC_CLKS : 0));
    hold_len   = setup_len;
    strobe_len = any_str ? CNT_W'(MC_CLKS * int'(sel)) : CNT_W'(HALF);
  end

  // R2: phase lengths add up to two base cycles plus the tabled stretch cycles
  always_comb begin
    assert_len_sum_R2: assert (int'(ale_len) + int'(setup_len) + int'(strobe_len)
                               + int'(hold_len)
                               == 2 * MC_CLKS + MC_CLKS * (hi_rng ? int'(sel) + 3 : int'(sel)));
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [2:0]       req_sel,
  input  logic [CNT_W-1:0] ale_len,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] hold_len,
  output logic [2:0]       sel_q,
  output logic             acc_en,
  output logic             cap_en,
  output phase_e           phase_q,
  output phase_e           phase_d
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cur_len;
  logic             at_end;

  assign acc_en = req && (phase_q == PH_IDLE);
  assign cap_en = (phase_q == PH_STROBE) && (phase_d == PH_HOLD);

  always_comb begin
    unique case (phase_q)
      PH_ALE:    cur_len = ale_len;
      PH_SETUP:  cur_len = setup_len;
      PH_STROBE: cur_len = strobe_len;
      PH_HOLD:   cur_len = hold_len;
      default:   cur_len = CNT_W'(1);
    endcase
    at_end = (cnt_q == cur_len - CNT_W'(1));
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CNT_W'(1);
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (req) phase_d = PH_ALE;
      end
      PH_ALE:    if (at_end) begin phase_d = PH_SETUP;  cnt_d = '0; end
      PH_SETUP:  if (at_end) begin phase_d = PH_STROBE; cnt_d = '0; end
      PH_STROBE: if (at_end) begin phase_d = PH_HOLD;   cnt_d = '0; end
      PH_HOLD:   if (at_end) begin phase_d = PH_DONE;   cnt_d = '0; end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (acc_en) sel_q <= req_sel;
    end
  end

  assert_sel_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(sel_q));

  assert_done_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 cap_en,
  input  phase_e               phase_d,
  input  logic                 req_wr,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W-1:0]    ad_in,
  output logic                 ale,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 done,
  output logic                 ad_oe,
  output logic [DATA_W-1:0]    ad_out,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              wr_q, wr_sel;
  logic [DATA_W-1:0] alo_q, alo_sel, wd_q, wd_sel;
  logic              ale_d, rd_n_d, wr_n_d, oe_d, done_d, in_data_ph;
  logic [DATA_W-1:0] out_d;

  always_comb begin
    wr_sel     = acc_en ? req_wr : wr_q;
    alo_sel    = acc_en ? req_addr[DATA_W-1:0] : alo_q;
    wd_sel     = acc_en ? req_wdata : wd_q;
    in_data_ph = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) || (phase_d == PH_HOLD);
    ale_d      = (phase_d == PH_ALE);
    rd_n_d     = !((phase_d == PH_STROBE) && !wr_sel);
    wr_n_d     = !((phase_d == PH_STROBE) && wr_sel);
    oe_d       = ale_d || (wr_sel && in_data_ph);
    out_d      = ale_d ? alo_sel : wd_sel;
    done_d     = (phase_d == PH_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      alo_q   <= '0;
      wd_q    <= '0;
      addr_hi <= '0;
      rd_data <= '0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ad_oe   <= 1'b0;
      ad_out  <= '0;
      done    <= 1'b0;
    end else begin
      if (acc_en) begin
        wr_q    <= req_wr;
        alo_q   <= req_addr[DATA_W-1:0];
        wd_q    <= req_wdata;
        addr_hi <= req_addr[ADDR_W-1:DATA_W];
      end
      if (cap_en && !wr_q) rd_data <= ad_in;
      ale    <= ale_d;
      rd_n   <= rd_n_d;
      wr_n   <= wr_n_d;
      ad_oe  <= oe_d;
      ad_out <= out_d;
      done   <= done_d;
    end
  end

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_ale_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_hi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> ($stable(addr_hi) && HI_W > 0));
endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int MC_CLKS = 4,
  parameter int CNT_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     req_wr,
  input  logic [2:0]               req_sel,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in
);
  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic [2:0]       sel_q;
  logic [CNT_W-1:0] ale_len, setup_len, strobe_len, hold_len;
  logic             acc_en, cap_en;
  phase_e           phase_q, phase_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign busy = (phase_q != PH_IDLE);

  xmem_stretch_decode #(.MC_CLKS(MC_CLKS), .CNT_W(CNT_W)) u_dec (
    .sel(sel_q), .ale_len(ale_len), .setup_len(setup_len),
    .strobe_len(strobe_len), .hold_len(hold_len)
  );

  xmem_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .req(req), .req_sel(req_sel),
    .ale_len(ale_len), .setup_len(setup_len), .strobe_len(strobe_len),
    .hold_len(hold_len), .sel_q(sel_q), .acc_en(acc_en), .cap_en(cap_en),
    .phase_q(phase_q), .phase_d(phase_d)
  );

  xmem_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_s_n), .acc_en(acc_en), .cap_en(cap_en),
    .phase_d(phase_d), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ad_in(ad_in), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .done(done), .ad_oe(ad_oe), .ad_out(ad_out),
    .addr_hi(addr_hi), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_xmem_stretch_ctrl.sv
module tb_xmem_stretch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [2:0]  req_sel = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0, ad_in = 8'h0;
  logic        busy, done, ale, rd_n, wr_n, ad_oe;
  logic [7:0]  rd_data, addr_hi, ad_out;

  int errors = 0, checks = 0, unexpected = 0;
  bit active = 0, finished = 0;

  typedef struct {
    bit wr; logic [15:0] addr; logic [7:0] data;
    int a; int s; int t; int h; int n;
  } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  xmem_stretch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_sel(req_sel),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t expect_for(bit wr, logic [2:0] sel, logic [15:0] addr, logic [7:0] data);
    exp_t e;
    int ntab[8] = '{0, 1, 2, 3, 7, 8, 9, 10};
    e.wr = wr; e.addr = addr; e.data = data;
    e.a = sel[2] ? 6 : 2;                          // R4, R5
    e.s = (sel == 0) ? 2 : (sel[2] ? 7 : 3);       // R4, R5
    e.t = (sel == 0) ? 2 : 4 * int'(sel);          // R3
    e.h = e.s;
    e.n = 8 + 4 * ntab[sel];                       // R2
    return e;
  endfunction

  task automatic access(input bit wr, input logic [2:0] sel, input logic [15:0] addr,
                        input logic [7:0] data);
    @(negedge clk);
    while (busy) @(negedge clk);
    sbq.push_back(expect_for(wr, sel, addr, data));
    req = 1; req_wr = wr; req_sel = sel; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req = 0;
  endtask

  // Monitor: measures each phase at the pins and compares with the queued item
  initial begin
    exp_t cur;
    int a = 0, s = 0, t = 0, h = 0;
    bit hi_ok = 1, port_ok = 1, strb_ok = 1, chk_low = 0;
    forever begin
      @(negedge clk);
      if (chk_low) begin
        check(done == 0, "R10 done single pulse", done, 0);
        chk_low = 0;
      end
      if (!active) begin
        if (ale) begin
          if (sbq.size() == 0) begin
            unexpected++;
            errors++;
            $display("FAIL R10 unexpected access actual=1 expected=0");
          end else begin
            cur = sbq.pop_front();
            active = 1; a = 1; s = 0; t = 0; h = 0;
            hi_ok = (addr_hi == cur.addr[15:8]);
            port_ok = ad_oe && (ad_out == cur.addr[7:0]);
            strb_ok = rd_n && wr_n;
          end
        end
      end else begin
        if (addr_hi != cur.addr[15:8]) hi_ok = 0;
        if (ale) begin
          a++;
          if (!(ad_oe && ad_out == cur.addr[7:0])) port_ok = 0;
          if (!rd_n || !wr_n) strb_ok = 0;
        end else if (!rd_n || !wr_n) begin
          t++;
          if (cur.wr ? (!wr_n == 0 || !rd_n) : (!rd_n == 0 || !wr_n)) strb_ok = 0;
          if (cur.wr ? !(ad_oe && ad_out == cur.data) : ad_oe) port_ok = 0;
          ad_in = (t == cur.t) ? cur.data : (~cur.data ^ 8'(t));
        end else if (done) begin
          check(a == cur.a, cur.a == 6 ? "R5 ale width" : "R4 ale width", a, cur.a);
          check(s == cur.s, cur.a == 6 ? "R5 setup gap" : "R4 setup gap", s, cur.s);
          check(h == cur.h, cur.a == 6 ? "R5 hold gap" : "R4 hold gap", h, cur.h);
          check(t == cur.t, "R3 strobe width", t, cur.t);
          check(a + s + t + h == cur.n, "R2 access length", a + s + t + h, cur.n);
          check(strb_ok, "R6 strobe selection", strb_ok, 1);
          check(port_ok, "R7 shared port contents", port_ok, 1);
          check(hi_ok, "R8 high address held", hi_ok, 1);
          if (!cur.wr) check(rd_data == cur.data, "R9 read capture", rd_data, cur.data);
          active = 0; chk_low = 1;
        end else if (t == 0) s++;
        else h++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!ale && rd_n && wr_n && !ad_oe && !done && !busy, "R1 idle after reset",
          {ale, rd_n, wr_n, ad_oe, done, busy}, 6'b011000);
    for (int k = 0; k < 8; k++) begin
      access(1'b0, 3'(k), 16'h1200 + 16'(k * 17), 8'h5A ^ 8'(k * 3));
      access(1'b1, 3'(k), 16'hA300 + 16'(k * 29), 8'hC3 + 8'(k));
    end
    // R10, R11: noisy request and setting changes during a long access
    access(1'b0, 3'd5, 16'hBEEF, 8'h7E);
    repeat (4) @(negedge clk);
    req = 1; req_sel = 3'd0; req_addr = 16'h0101; req_wr = 1;
    repeat (6) @(negedge clk);
    req_sel = 3'd7;
    repeat (4) @(negedge clk);
    req = 0;
    access(1'b1, 3'd1, 16'h00FF, 8'h81);
    @(negedge clk);
    while (busy || active || sbq.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(unexpected == 0, "R10 request while busy ignored", unexpected, 0);
    check(sbq.size() == 0, "R11 all accesses completed", sbq.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule